// File: doc/BRIEF.md
# Power-Management Reset Output Controller

This block drives two active-low reset lines from a power-management controller. One goes to the host processor and one goes to a memory subsystem. It follows the system power state: off, start-up, active, hibernate or shutdown. When the supplies report good at start-up, it holds both lines low for a programmable number of millisecond ticks and then releases them.

Each line has its own hibernate level. The host line can also wait for a valid oscillator when crystal-detect is enabled. Both lines can be pulled low by a manual reset pin or by a self-clearing software reset bit. A memory-valid flag is kept for software. It is cleared whenever the state sequence itself asserts the memory reset.

Timing is counted in pulses of `tick_ms`, one per millisecond in a real system. This lets a bench shorten the tick period. Register writes use a small write port. Address 0 holds the hold select in bits [1:0], the software reset in bit 2 and the memory-valid flag in bit 3. Address 1 holds the host hibernate level in bit 0 and the memory hibernate level in bit 1.

Top module: `pm_rst_ctrl`

## Requirements
- R1: State code 0 (off), and any code above 4, drives both `host_rst_n` and `mem_rst_n` low. After reset both outputs read low and `mem_valid` reads 0.
- R2: In start-up (code 1) or active (code 2) with `pwr_good` high, the first such cycle after off or shutdown starts a hold. Both outputs stay low until the hold ends and then go high. The hold select defaults to 3, which is 120 ticks.
- R3: The hold length in ticks is 15 shifted left by the 2-bit select: 0→15, 1→30, 2→60, 3→120.
- R4: State code 4 (shutdown) drives both outputs low.
- R5: In hibernate (code 3), `host_rst_n` equals address 1 bit 0 and `mem_rst_n` equals address 1 bit 1. A value of 0 means low. Both bits default to 0.
- R6: With `xtal_det_en` high, `host_rst_n` stays low after the hold until `osc_valid` has been seen high. `mem_rst_n` is not delayed by this.
- R7: While the synchronised `mr_n` is low, both outputs are low. After `mr_n` rises, the selected hold runs before release. `mem_valid` is not changed by the manual reset.
- R8: Writing address 0 with bit 2 set starts a hold at the select written in the same access. The bit does not stay set. A new software reset during a hold restarts the full hold.
- R9: `mem_valid` is cleared while the state sequence holds the memory reset low: off, shutdown, start-up before release, or hibernate with address 1 bit 1 at 0. Outside those cases, a write to address 0 loads it from bit 3. Software and manual resets do not clear it.
- R10: A write to address 0 loads the hold select from bits [1:0]. Address 1 writes do not change the hold select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| sys_state | input | 3 | Power state: 0 off, 1 start-up, 2 active, 3 hibernate, 4 shutdown |
| pwr_good | input | 1 | All enabled supplies at or above 90% of target |
| xtal_det_en | input | 1 | Crystal-detect gating of the host reset |
| osc_valid | input | 1 | Oscillator frequency confirmed valid |
| mr_n | input | 1 | Asynchronous manual reset, active low |
| tick_ms | input | 1 | One-cycle timing pulse, nominally 1 ms |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Register address |
| wr_data | input | 4 | Register write data |
| host_rst_n | output | 1 | Host reset, active low |
| mem_rst_n | output | 1 | Memory reset, active low |
| mem_valid | output | 1 | Memory contents valid flag |

## Verification
The assertions assume that `sys_state` and the write port are synchronous to `clk` and that each software reset lasts a single write cycle. They also assume that `tick_ms` is a one-cycle pulse that never coincides with the edge at which a hold is loaded. The bench changes every input at the falling edge and issues each write as a single-cycle strobe. It separates ticks by an idle cycle. It only moves `mr_n` between tick bursts, so the synchroniser latency never overlaps a tick.

// File: rtl/pm_rst_pkg.sv
package pm_rst_pkg;
  typedef enum logic [2:0] {
    ST_OFF  = 3'd0,
    ST_UP   = 3'd1,
    ST_ACT  = 3'd2,
    ST_HIB  = 3'd3,
    ST_DOWN = 3'd4
  } pm_state_e;

  // hold length in ticks for a 2-bit select
  function automatic int unsigned hold_ticks(int unsigned base, logic [1:0] sel);
    return base << sel;
  endfunction
endpackage

// File: rtl/pm_rst_sync.sv
module pm_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic d_out
);
  logic [STAGES-1:0] stg_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[i] <= 1'b1;
        else if (i == 0) stg_q[i] <= d_in;
        else stg_q[i] <= stg_q[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign d_out = stg_q[STAGES-1];
endmodule

// File: rtl/pm_rst_regs.sv
module pm_rst_regs (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       wr_addr,
  input  logic [3:0] wr_data,
  input  logic       mem_clr,
  output logic [1:0] sel_nxt,
  output logic       sw_go,
  output logic       hib_host_rel,
  output logic       hib_mem_rel,
  output logic       mem_valid
);
  logic [1:0] sel_q;
  logic       wr_ctl;
  logic       wr_hib;

  assign wr_ctl  = wr_en && !wr_addr;
  assign wr_hib  = wr_en && wr_addr;
  assign sel_nxt = wr_ctl ? wr_data[1:0] : sel_q;
  assign sw_go   = wr_ctl && wr_data[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q        <= 2'b11;
      hib_host_rel <= 1'b0;
      hib_mem_rel  <= 1'b0;
      mem_valid    <= 1'b0;
    end else begin
      sel_q <= sel_nxt;
      if (wr_hib) begin
        hib_host_rel <= wr_data[0];
        hib_mem_rel  <= wr_data[1];
      end
      if (mem_clr) mem_valid <= 1'b0;
      else if (wr_ctl) mem_valid <= wr_data[3];
    end
  end
endmodule

// File: rtl/pm_rst_timer.sv
module pm_rst_timer #(
  parameter int unsigned BASE_TICKS = 15,
  parameter int unsigned CNT_W      = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       sel,
  input  logic             tick,
  output logic [CNT_W-1:0] cnt,
  output logic             busy
);
  logic [CNT_W-1:0] load_val;

  assign load_val = CNT_W'(pm_rst_pkg::hold_ticks(BASE_TICKS, sel));
  assign busy     = (cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (start) cnt <= load_val;
    else if (tick && busy) cnt <= cnt - 1'b1;
  end
endmodule

// File: rtl/pm_rst_ctrl.sv
module pm_rst_ctrl #(
  parameter int unsigned BASE_TICKS  = 15,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] sys_state,
  input  logic       pwr_good,
  input  logic       xtal_det_en,
  input  logic       osc_valid,
  input  logic       mr_n,
  input  logic       tick_ms,
  input  logic       wr_en,
  input  logic       wr_addr,
  input  logic [3:0] wr_data,
  output logic       host_rst_n,
  output logic       mem_rst_n,
  output logic       mem_valid
);
  import pm_rst_pkg::*;

  localparam int unsigned MAX_TICKS = hold_ticks(BASE_TICKS, 2'b11);
  localparam int unsigned CNT_W     = $clog2(MAX_TICKS + 1);

  logic             mr_sync;
  logic             mr_act;
  logic             pg_go;
  logic             sw_go;
  logic             hold_start;
  logic             hold_busy;
  logic [CNT_W-1:0] hold_cnt;
  logic [1:0]       sel_nxt;
  logic             hib_host_rel;
  logic             hib_mem_rel;
  logic             mem_clr;
  logic             host_low;
  logic             mem_low;
  logic             fresh_q;
  logic             osc_ok_q;
  logic             st_run;
  logic             st_dead;
  logic             st_hib;

  pm_rst_sync #(.STAGES(SYNC_STAGES)) u_mr_sync (
    .clk(clk), .rst_n(rst_n), .d_in(mr_n), .d_out(mr_sync)
  );
  assign mr_act = !mr_sync;

  pm_rst_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .mem_clr(mem_clr), .sel_nxt(sel_nxt),
    .sw_go(sw_go), .hib_host_rel(hib_host_rel),
    .hib_mem_rel(hib_mem_rel), .mem_valid(mem_valid)
  );

  assign st_run  = (sys_state == ST_UP) || (sys_state == ST_ACT);
  assign st_hib  = (sys_state == ST_HIB);
  assign st_dead = !st_run && !st_hib;
  assign pg_go   = st_run && fresh_q && pwr_good;
  assign hold_start = pg_go || sw_go || mr_act;

  pm_rst_timer #(.BASE_TICKS(BASE_TICKS), .CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(hold_start), .sel(sel_nxt),
    .tick(tick_ms), .cnt(hold_cnt), .busy(hold_busy)
  );

  // memory reset asserted by the state sequence itself
  assign mem_clr = st_dead || (st_hib && !hib_mem_rel) || (st_run && fresh_q);

  always_comb begin
    if (st_dead) begin
      mem_low  = 1'b1;
      host_low = 1'b1;
    end else if (st_hib) begin
      mem_low  = !hib_mem_rel || mr_act || hold_busy;
      host_low = !hib_host_rel || mr_act || hold_busy;
    end else begin
      mem_low  = fresh_q || mr_act || hold_busy;
      host_low = mem_low || (xtal_det_en && !osc_ok_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fresh_q    <= 1'b1;
      osc_ok_q   <= 1'b0;
      host_rst_n <= 1'b0;
      mem_rst_n  <= 1'b0;
    end else begin
      if (st_dead) fresh_q <= 1'b1;
      else if (pg_go) fresh_q <= 1'b0;
      if (st_dead) osc_ok_q <= 1'b0;
      else if (osc_valid) osc_ok_q <= 1'b1;
      host_rst_n <= !host_low;
      mem_rst_n  <= !mem_low;
    end
  end
endmodule

module pm_rst_ctrl_chk #(
  parameter int unsigned CNT_W     = 7,
  parameter int unsigned MAX_TICKS = 120
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       sys_state,
  input logic             mr_act,
  input logic             sw_go,
  input logic             hold_busy,
  input logic [CNT_W-1:0] hold_cnt,
  input logic             mem_clr,
  input logic             hib_host_rel,
  input logic             host_rst_n,
  input logic             mem_rst_n,
  input logic             mem_valid
);
  p_off_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_state == 3'd0) |=> (!host_rst_n && !mem_rst_n));

  p_down_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_state == 3'd4) |=> (!host_rst_n && !mem_rst_n));

  p_hib_host_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_state == 3'd3 && !hib_host_rel) |=> !host_rst_n);

  p_mr_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mr_act |=> (!host_rst_n && !mem_rst_n));

  p_sw_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sw_go |=> hold_busy);

  p_hold_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hold_busy |=> !mem_rst_n);

  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    32'(hold_cnt) <= MAX_TICKS);

  p_mem_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_clr |=> !mem_valid);
endmodule

bind pm_rst_ctrl pm_rst_ctrl_chk #(.CNT_W(CNT_W), .MAX_TICKS(MAX_TICKS)) u_chk (
  .clk(clk), .rst_n(rst_n), .sys_state(sys_state), .mr_act(mr_act),
  .sw_go(sw_go), .hold_busy(hold_busy), .hold_cnt(hold_cnt),
  .mem_clr(mem_clr), .hib_host_rel(hib_host_rel),
  .host_rst_n(host_rst_n), .mem_rst_n(mem_rst_n), .mem_valid(mem_valid)
);

// File: tb/pm_rst_ctrl_tb_top.sv
module pm_rst_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] sys_state = 3'd0;
  logic       pwr_good = 1'b0;
  logic       xtal_det_en = 1'b0;
  logic       osc_valid = 1'b0;
  logic       mr_n = 1'b1;
  logic       tick_ms = 1'b0;
  logic       wr_en = 1'b0;
  logic       wr_addr = 1'b0;
  logic [3:0] wr_data = 4'd0;
  logic       host_rst_n;
  logic       mem_rst_n;
  logic       mem_valid;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pm_rst_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .sys_state(sys_state), .pwr_good(pwr_good),
    .xtal_det_en(xtal_det_en), .osc_valid(osc_valid), .mr_n(mr_n),
    .tick_ms(tick_ms), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .host_rst_n(host_rst_n), .mem_rst_n(mem_rst_n), .mem_valid(mem_valid)
  );

  function automatic int hold_len(int sel);
    int v = 15;
    for (int k = 0; k < sel; k++) v = v * 2;
    return v;
  endfunction

  task automatic check(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ticks(int n);
    repeat (n) begin
      @(negedge clk); tick_ms = 1'b1;
      @(negedge clk); tick_ms = 1'b0;
    end
  endtask

  task automatic write(logic a, logic [3:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic t_reset_off();
    check("R1", "host after reset", host_rst_n, 0);
    check("R1", "mem after reset", mem_rst_n, 0);
    check("R1", "mem_valid after reset", mem_valid, 0);
    pwr_good = 1'b1;
    cycles(4);
    check("R1", "host in off with power good", host_rst_n, 0);
    check("R1", "mem in off with power good", mem_rst_n, 0);
  endtask

  task automatic t_startup_default();
    sys_state = 3'd1;
    cycles(3);
    ticks(hold_len(3) - 1);
    check("R2", "host before default hold end", host_rst_n, 0);
    check("R2", "mem before default hold end", mem_rst_n, 0);
    ticks(1);
    cycles(2);
    check("R2", "host after 120 ticks", host_rst_n, 1);
    check("R2", "mem after 120 ticks", mem_rst_n, 1);
    sys_state = 3'd2;
    cycles(2);
  endtask

  task automatic t_mem_set();
    write(1'b0, 4'b1011);
    cycles(1);
    check("R9", "mem_valid after software set", mem_valid, 1);
    check("R10", "hold select write alone no reset", mem_rst_n, 1);
  endtask

  task automatic t_sw_sel(int sel);
    write(1'b0, {2'b11, 2'(sel)});
    cycles(2);
    check("R8", "host low after software reset", host_rst_n, 0);
    ticks(hold_len(sel) - 1);
    check("R3", $sformatf("mem still low sel=%0d", sel), mem_rst_n, 0);
    ticks(1);
    cycles(2);
    check("R3", $sformatf("mem released sel=%0d", sel), mem_rst_n, 1);
    check("R8", "host released, bit self-clears", host_rst_n, 1);
    check("R9", "software reset keeps mem_valid", mem_valid, 1);
  endtask

  task automatic t_sw_restart();
    write(1'b0, 4'b1100);
    ticks(10);
    write(1'b0, 4'b1100);
    ticks(10);
    check("R8", "restarted hold still low", mem_rst_n, 0);
    ticks(4);
    check("R8", "restarted hold one tick left", host_rst_n, 0);
    ticks(1);
    cycles(2);
    check("R8", "restarted hold released", host_rst_n, 1);
  endtask

  task automatic t_manual();
    @(negedge clk); mr_n = 1'b0;
    cycles(5);
    check("R7", "host low during manual reset", host_rst_n, 0);
    ticks(40);
    check("R7", "mem held while manual reset asserted", mem_rst_n, 0);
    @(negedge clk); mr_n = 1'b1;
    cycles(5);
    check("R7", "still low right after release", mem_rst_n, 0);
    ticks(hold_len(0) - 1);
    check("R7", "hold after release not done", host_rst_n, 0);
    ticks(1);
    cycles(2);
    check("R7", "host released after hold", host_rst_n, 1);
    check("R7", "mem released after hold", mem_rst_n, 1);
    check("R7", "manual reset keeps mem_valid", mem_valid, 1);
  endtask

  task automatic t_hibernate();
    write(1'b1, 4'b0001);
    @(negedge clk); sys_state = 3'd3;
    cycles(3);
    check("R5", "host in hibernate mode 1", host_rst_n, 1);
    check("R5", "mem in hibernate mode 0", mem_rst_n, 0);
    check("R9", "mem_valid cleared by hibernate memory reset", mem_valid, 0);
    write(1'b1, 4'b0010);
    cycles(2);
    check("R5", "host in hibernate mode 0", host_rst_n, 0);
    check("R5", "mem in hibernate mode 1", mem_rst_n, 1);
    write(1'b0, 4'b1000);
    cycles(1);
    check("R9", "mem_valid set while memory reset released", mem_valid, 1);
    @(negedge clk); sys_state = 3'd2;
    cycles(3);
    check("R10", "hibernate write leaves select at 0 (15)", host_rst_n, 1);
  endtask

  task automatic t_shutdown();
    @(negedge clk); sys_state = 3'd4;
    cycles(3);
    check("R4", "host in shutdown", host_rst_n, 0);
    check("R4", "mem in shutdown", mem_rst_n, 0);
    check("R9", "mem_valid cleared in shutdown", mem_valid, 0);
    @(negedge clk); sys_state = 3'd6;
    cycles(3);
    check("R1", "unused state code low", host_rst_n, 0);
  endtask

  task automatic t_xtal();
    @(negedge clk); sys_state = 3'd0; xtal_det_en = 1'b1; osc_valid = 1'b0;
    cycles(3);
    @(negedge clk); sys_state = 3'd1;
    cycles(2);
    ticks(hold_len(0));
    cycles(2);
    check("R6", "mem released after hold", mem_rst_n, 1);
    check("R6", "host waits for oscillator", host_rst_n, 0);
    @(negedge clk); osc_valid = 1'b1;
    cycles(3);
    check("R6", "host released once oscillator valid", host_rst_n, 1);
  endtask

  initial begin
    cycles(3);
    rst_n = 1'b1;
    cycles(2);
    t_reset_off();
    t_startup_default();
    t_mem_set();
    t_sw_sel(0);
    t_sw_sel(1);
    t_sw_sel(2);
    t_sw_restart();
    t_manual();
    t_hibernate();
    t_shutdown();
    t_xtal();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule